// File: doc/BRIEF.md
# Synchronous Burst Memory Access Controller

This block sits on the host side of a pseudo-static memory that supports synchronous bursts. It accepts one request at a time: a start address and a direction. It drives chip enable, an address-valid strobe, write enable, the memory clock and the address bus. After the address has been captured, it waits a configured number of latency cycles. It then moves one data word on every rising edge at which the memory's WAIT input is low. WAIT may also rise in the middle of a burst, for example while the memory restores a row after the burst has stepped across a 128-word row boundary. The controller simply holds its position until WAIT falls again.

The burst size is chosen per request with a two-bit code. It selects a fixed length of 4, 8 or 16 words, or an open-ended burst that runs until the host raises a stop input. Transfers are visible to the host on the same edge they happen on the memory bus. For a write, a word is consumed when `wr_valid` and `wr_ready` are both high. For a read, `rd_valid` marks a word on `rd_data`. During the data phase, `mem_addr` carries the address of the word that is about to move.

Top module: `burst_ctrl`

## Requirements
- R1: Out of reset and while idle: `mem_ce_n` = 1, `mem_adv_n` = 1, `mem_we_n` = 1, `req_ready` = 1, `rd_valid` = 0, `wr_ready` = 0.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both high. In the next cycle `mem_ce_n` = 0 and `mem_adv_n` = 0 for exactly one cycle, with `mem_addr` equal to `req_addr`. `mem_we_n` is 0 for a write (`req_write` = 1) and 1 for a read, and it holds that value for the whole burst.
- R3: With latency code L on `cfg_lat` at acceptance, the data phase begins in the (L+2)-th cycle after the accepting edge. Before that cycle, no word moves, whatever `mem_wait` does.
- R4: In the data phase, no word moves in a cycle where `mem_wait` is 1. In a cycle where `mem_wait` is 0, `rd_valid` (read) or `wr_ready` (write) is 1.
- R5: `cfg_len` codes 0, 1 and 2 give bursts of 4, 8 and 16 words. In the cycle after the last word moves, `mem_ce_n` = 1 and `req_ready` = 1.
- R6: `cfg_len` code 3 gives a continuous burst. An edge in the data phase with `stop` = 1 ends it: no word moves on that edge, and `mem_ce_n` = 1 in the next cycle. `stop` has no effect on fixed-length bursts.
- R7: During the data phase, `mem_addr` starts at the request address and increases by one after each word that moves. It carries across 128-word row boundaries and wraps at the top of the address space.
- R8: In a write data phase, `mem_dq_oe` = 1 and `mem_dq_out` equals `wr_data`. A word counts as moved only on an edge where `wr_valid` is also 1. `mem_dq_oe` = 0 at all other times.
- R9: When `rd_valid` = 1, `rd_data` equals `mem_dq_in`.
- R10: `mem_clk` follows `clk` while `mem_ce_n` = 0 and is held at 0 while `mem_ce_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len | input | 2 | Burst length code: 0=4, 1=8, 2=16, 3=continuous |
| cfg_lat | input | LW | Initial latency in cycles |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Controller idle, request accepted when both high |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | AW | Burst start word address |
| stop | input | 1 | Ends a continuous burst |
| wr_data | input | DW | Write word from the host |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Write word taken this edge (with wr_valid) |
| rd_data | output | DW | Read word to the host |
| rd_valid | output | 1 | Read word valid this edge |
| mem_clk | output | 1 | Memory clock |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Start address, then current word address |
| mem_dq_out | output | DW | Write data to the memory |
| mem_dq_oe | output | 1 | Write data drive enable |
| mem_dq_in | input | DW | Read data from the memory |
| mem_wait | input | 1 | Memory not ready for a word |

## Verification
The bench builds the controller with a 10-bit address, 16-bit data and the default 4-bit latency field. The narrow address makes the wrap at the top of memory reachable within a short continuous burst, while still leaving several 128-word rows for row-crossing stalls. The latency field allows every value from 0 to 15, so the bench can cover both the no-wait path from the address cycle straight to the data phase and the longest wait.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_LAT  = 2'd2,
        ST_XFER = 2'd3
    } bst_state_e;

    localparam logic [1:0] LEN_CONT        = 2'd3;
    localparam int         MAX_FIXED_WORDS = 16;

endpackage

// File: rtl/burst_len_ctr.sv
module burst_len_ctr
    import burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] len_code,
    input  logic       dec,
    output logic       last,
    output logic       cont
);
    localparam int CW = $clog2(MAX_FIXED_WORDS + 1);

    typedef struct packed {
        logic          cont;
        logic [CW-1:0] left;
    } len_t;

    len_t len_d, len_q;

    always_comb begin
        len_d = len_q;
        if (load) begin
            len_d.cont = (len_code == LEN_CONT);
            len_d.left = (len_code == LEN_CONT) ? '0 : (CW'(4) << len_code);
        end else if (dec && !len_q.cont) begin
            len_d.left = len_q.left - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) len_q <= '{cont: 1'b0, left: '0};
        else        len_q <= len_d;
    end

    assign last = !len_q.cont && (len_q.left == CW'(1));
    assign cont = len_q.cont;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !len_q.cont) |-> (len_q.left != '0)); // R5
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
    parameter int AW    = 23,
    parameter int ROW_W = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load)     addr_d = addr_in;
        else if (inc) addr_d = addr_q + AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_q == $past(addr_in))); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (addr_q == $past(addr_q) + AW'(1))); // R7
    AST_ROW_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && (addr_q[ROW_W-1:0] == '1)) |=> (addr_q[ROW_W-1:0] == '0)); // R7
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_pkg::*;
#(
    parameter int AW    = 23,
    parameter int DW    = 16,
    parameter int LW    = 4,
    parameter int ROW_W = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_len,
    input  logic [LW-1:0] cfg_lat,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic          stop,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_valid,
    output logic          wr_ready,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          mem_clk,
    output logic          mem_ce_n,
    output logic          mem_adv_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in,
    input  logic          mem_wait
);
    typedef struct packed {
        bst_state_e    st;
        logic          wr;
        logic [LW-1:0] lat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic accept;
    logic in_xfer;
    logic halt;
    logic open_slot;
    logic beat;
    logic last;
    logic cont;

    assign accept    = req_valid && (ctl_q.st == ST_IDLE);
    assign in_xfer   = (ctl_q.st == ST_XFER);
    assign halt      = in_xfer && cont && stop;
    assign open_slot = in_xfer && !mem_wait && !(cont && stop);
    assign beat      = open_slot && (!ctl_q.wr || wr_valid);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st  = ST_ADDR;
                    ctl_d.wr  = req_write;
                    ctl_d.lat = cfg_lat;
                end
            end
            ST_ADDR: begin
                ctl_d.st = (ctl_q.lat == '0) ? ST_XFER : ST_LAT;
            end
            ST_LAT: begin
                ctl_d.lat = ctl_q.lat - LW'(1);
                if (ctl_q.lat == LW'(1)) ctl_d.st = ST_XFER;
            end
            ST_XFER: begin
                if (halt || (beat && last)) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, wr: 1'b0, lat: '0};
        else        ctl_q <= ctl_d;
    end

    burst_len_ctr i_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .len_code (cfg_len),
        .dec      (beat),
        .last     (last),
        .cont     (cont)
    );

    burst_addr_ctr #(.AW(AW), .ROW_W(ROW_W)) i_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .addr_in (req_addr),
        .inc     (beat),
        .addr    (mem_addr)
    );

    assign req_ready  = (ctl_q.st == ST_IDLE);
    assign mem_ce_n   = (ctl_q.st == ST_IDLE);
    assign mem_adv_n  = (ctl_q.st != ST_ADDR);
    assign mem_we_n   = !((ctl_q.st != ST_IDLE) && ctl_q.wr);
    assign mem_clk    = clk & ~mem_ce_n;
    assign wr_ready   = open_slot && ctl_q.wr;
    assign rd_valid   = open_slot && !ctl_q.wr;
    assign rd_data    = mem_dq_in;
    assign mem_dq_out = wr_data;
    assign mem_dq_oe  = in_xfer && ctl_q.wr;

    AST_ACCEPT_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!mem_ce_n && !mem_adv_n)); // R2
    AST_ADV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |=> mem_adv_n); // R2
    AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_we_n)); // R2
    AST_WAIT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wait |-> (!rd_valid && !wr_ready)); // R4
    AST_END_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && last) |=> (mem_ce_n && req_ready)); // R5
    AST_STOP_END: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> mem_ce_n); // R6
endmodule

// File: tb/test_burst_ctrl.sv
`timescale 1ns/1ps
module test_burst_ctrl;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_len = '0;
    logic [LW-1:0] cfg_lat = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          stop = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          mem_clk;
    logic          mem_ce_n;
    logic          mem_adv_n;
    logic          mem_we_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic          mem_dq_oe;
    logic [DW-1:0] mem_dq_in = '0;
    logic          mem_wait = 1'b0;

    always #10 clk = ~clk;

    burst_ctrl #(.AW(AW), .DW(DW), .LW(LW)) i_burst_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_lat(cfg_lat),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .stop(stop), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_clk(mem_clk), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
    );

    int checks = 0;
    int errors = 0;

    // Reference model: k counts cycles since the accepting edge (0 = idle)
    int            k = 0;
    int            n = 0;
    int            total = 0;
    bit            m_wr = 0;
    bit            m_cont = 0;
    int            m_lat = 0;
    logic [AW-1:0] m_start = '0;
    int            rs = 0;
    int            wait_pct = 0;
    int            wv_pct = 100;
    int            stop_at = -1;
    int            cyc = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rdpat(input logic [AW-1:0] a);
        return (DW'(a) * 16'd7) ^ 16'h5A5A;
    endfunction

    task automatic step(input bit req);
        logic [AW-1:0] cur_a;
        bit xwin;
        bit open_s;
        bit beat;
        @(negedge clk);
        cur_a     = m_start + AW'(n);
        xwin      = (k != 0) && (k >= m_lat + 2);
        req_valid = req;
        mem_wait  = (rs > 0) ? 1'b1 : ($urandom_range(99) < wait_pct);
        stop      = (stop_at >= 0) && (cyc >= stop_at);
        wr_valid  = ($urandom_range(99) < wv_pct);
        wr_data   = DW'(16'hC000 + n);
        mem_dq_in = rdpat(cur_a);
        #1;
        open_s = xwin && !mem_wait && !(m_cont && stop);
        if (k == 0) begin
            chk("R1 ce_n idle", 32'(mem_ce_n), 32'd1);
            chk("R1 adv_n idle", 32'(mem_adv_n), 32'd1);
            chk("R1 we_n idle", 32'(mem_we_n), 32'd1);
            chk("R1 req_ready idle", 32'(req_ready), 32'd1);
            chk("R1 rd_valid idle", 32'(rd_valid), 32'd0);
            chk("R1 wr_ready idle", 32'(wr_ready), 32'd0);
            chk("R8 dq_oe idle", 32'(mem_dq_oe), 32'd0);
        end else begin
            chk("R2 ce_n active", 32'(mem_ce_n), 32'd0);
            chk("R2 req_ready busy", 32'(req_ready), 32'd0);
            chk("R2 adv_n", 32'(mem_adv_n), (k == 1) ? 32'd0 : 32'd1);
            chk("R2 we_n", 32'(mem_we_n), m_wr ? 32'd0 : 32'd1);
            if (k == 1) chk("R2 start addr", 32'(mem_addr), 32'(m_start));
            if (!xwin) begin
                chk("R3 no read before latency", 32'(rd_valid), 32'd0);
                chk("R3 no write before latency", 32'(wr_ready), 32'd0);
            end else begin
                chk("R4 rd_valid vs wait", 32'(rd_valid), 32'(open_s && !m_wr));
                chk("R4 wr_ready vs wait", 32'(wr_ready), 32'(open_s && m_wr));
                chk("R7 word addr", 32'(mem_addr), 32'(cur_a));
                if (open_s && !m_wr) chk("R9 rd_data", 32'(rd_data), 32'(rdpat(cur_a)));
                if (m_wr) chk("R8 dq_out", 32'(mem_dq_out), 32'(wr_data));
            end
            chk("R8 dq_oe", 32'(mem_dq_oe), 32'(xwin && m_wr));
        end
        if (rs > 0) rs--;
        if (k == 0) begin
            if (req) begin
                k = 1; n = 0; cyc = 0;
                m_wr = req_write; m_cont = (cfg_len == 2'd3);
                total = 4 << cfg_len; m_lat = int'(cfg_lat); m_start = req_addr;
            end
        end else if (xwin) begin
            beat = open_s && (!m_wr || wr_valid);
            if (m_cont && stop) begin
                k = 0;
            end else begin
                if (beat) begin
                    if (cur_a[6:0] == 7'h7F) rs = 2;
                    n++;
                    if (!m_cont && n == total) k = 0;
                end
                if (k != 0) k++;
            end
        end else begin
            k++;
        end
        cyc++;
        @(posedge clk);
        #1;
        chk("R10 mem_clk", 32'(mem_clk), 32'(k != 0));
    endtask

    task automatic burst(input bit wr, input logic [AW-1:0] a, input logic [1:0] len,
                         input int lat, input int wp, input int vp, input int sa,
                         input string tag);
        int guard = 0;
        int prev_err = errors;
        cfg_len = len; cfg_lat = LW'(lat); req_write = wr; req_addr = a;
        wait_pct = wp; wv_pct = vp; stop_at = sa;
        step(1);
        while (k != 0 && guard < 3000) begin
            step(0);
            guard++;
        end
        step(0);
        if (errors != prev_err) $display("burst %s had mismatches", tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        chk("R1 ce_n in reset", 32'(mem_ce_n), 32'd1);
        chk("R1 req_ready in reset", 32'(req_ready), 32'd1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(0);
        step(0);
        // R5 fixed lengths, R4 wait, R8 write, R9 read
        burst(0, 10'h010, 2'd0, 2, 0, 100, -1, "read4");
        burst(1, 10'h020, 2'd1, 3, 30, 70, -1, "write8");
        burst(0, 10'h000, 2'd1, 7, 50, 100, -1, "read8 heavy wait");
        burst(1, 10'h200, 2'd2, 0, 0, 100, -1, "write16 zero latency");
        // R7 row crossing inside a 16-word read
        burst(0, 10'h07A, 2'd2, 0, 20, 100, -1, "read16 row cross");
        // R6 stop ignored on a fixed burst
        burst(0, 10'h100, 2'd0, 1, 25, 100, 0, "read4 stop ignored");
        // R6 continuous read wrapping at the top of memory (R7)
        burst(0, 10'h3F0, 2'd3, 4, 20, 100, 40, "cont read wrap");
        // R3 longest latency on a continuous write
        burst(1, 10'h17C, 2'd3, 15, 25, 60, 45, "cont write max latency");
        // back-to-back bursts
        for (int i = 0; i < 6; i++) begin
            burst(bit'(i % 2), AW'(i * 97), 2'(i % 4), i * 2, 30, 80, 25, "mixed");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule